// File: doc/BRIEF.md
# Service-Key Watchdog with Early-Warning Interrupt

This block is a watchdog timer that software drives through a small 16-bit register port. Once software enables it with a nonzero timeout, an internal counter steps down by one on every strobe of a half-second tick input. Software must keep it alive by writing two fixed key words, one after the other, to a service register. If the counter reaches zero, the block records a timeout cause and raises a one-cycle reset-request pulse for the system reset controller.

A control write with the software-reset bit at 0 also records a cause and can request a reset. Some control bits can be written only once. An optional early-warning stage raises an interrupt a programmable number of ticks before expiry. Its enable and threshold lock after the first write, but its status bit can always be cleared by writing 1 to it.

The register port has no handshake. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address.

Top module: `wdog_pretimeout`

## Requirements
- R1: After reset, the registers read as follows: control (offset 0x0) 0x0030, service (0x2) 0x0000, cause (0x4) 0x0000, interrupt control (0x6) 0x0004, misc (0x8) 0x0001, and any other offset 0x0000. `rst_req_o` and `irq_o` are low.
- R2: Control bits [15:8] hold the timeout T and bit 2 is the enable. A control write with enable=1 and T≠0 restarts the counter at T+1. The counter then expires on the (T+1)-th tick. With enable=0 or T=0, the counter does not run.
- R3: A service write of 0x5555 immediately followed by a service write of 0xAAAA reloads the counter to T+1. Any other service write in between breaks the pair. The service register reads back the last value written to it.
- R4: On expiry, the cause register reads 0x0002 and `rst_req_o` is high for exactly the one cycle after the clock edge that took the final tick.
- R5: A control write with bit 4 = 0 sets the cause register to 0x0001. Bit 4 always reads back as 1.
- R6: A control write requests an immediate reset pulse on `rst_req_o` in either of two cases:
  - bits 5 and 4 are both 0;
  - the resulting enable is 1 with T = 0.
- R7: Once enable has been written as 1, it stays 1 until reset. Control bits [1:0] keep the value of the first control write.
- R8: Interrupt control bit 15 is the interrupt enable and bits [7:0] are the threshold H. The early warning is armed only by one of two writes:
  - a control write that starts the counter at a value above H;
  - an interrupt-control write while the counter is running with a count above H.
  When an armed counter reaches H, bit 14 sets and `irq_o` rises.
- R9: Writing 1 to interrupt control bit 14 clears it and drops `irq_o`. Bit 15 and bits [7:0] keep the values of the first interrupt-control write.
- R10: A service reload does not re-arm an early warning that has already fired or has been disarmed.
- R11: With the pretimeout parameter off, interrupt-control writes have no effect: the register reads 0x0004 and `irq_o` stays low.
- R12: The misc register at 0x8 keeps only bit 0, which is writable.
- R13: A tick that arrives in the same cycle as any register write is dropped and does not decrement the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle half-second strobe |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 4 | Register byte offset |
| csr_wdata_i | input | 16 | Write data |
| csr_rdata_o | output | 16 | Read data for `csr_addr_i` |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Early-warning interrupt level |

## Verification
The hardest state to reach from the ports is an early warning that stays quiet after a service reload. Reaching it needs three things in order: the interrupt must fire, it must be cleared by a write made exactly when the count equals the threshold (so that write does not re-arm), and only then may the key pair reload the counter. The stimulus runs this order, then steps the counter back through the threshold and expects `irq_o` to stay low. A behavioural model tracks the count, the arming and the causes on every clock. It catches any misplaced reload, rearm or dropped tick as a mismatch on `rst_req_o` or `irq_o`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 16;
  localparam int AW    = 4;
  localparam int TO_W  = 8;

  localparam logic [AW-1:0] OFF_CTL  = 4'h0;
  localparam logic [AW-1:0] OFF_SVC  = 4'h2;
  localparam logic [AW-1:0] OFF_WHY  = 4'h4;
  localparam logic [AW-1:0] OFF_ICR  = 4'h6;
  localparam logic [AW-1:0] OFF_MISC = 4'h8;

  // control register fields
  localparam int CB_LOCK_LO = 0;
  localparam int CB_LOCK_HI = 1;
  localparam int CB_EN      = 2;
  localparam int CB_SWRST_N = 4;
  localparam int CB_ASSERT  = 5;
  localparam int CB_TO_LSB  = 8;

  // interrupt control fields
  localparam int IB_IE   = 15;
  localparam int IB_STAT = 14;

  localparam logic [REG_W-1:0] CTL_RST = 16'h0030;

  typedef enum logic [1:0] {
    WHY_NONE = 2'b00,
    WHY_SOFT = 2'b01,
    WHY_TOUT = 2'b10
  } why_e;
endpackage

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          start_i,
  input  logic          reload_i,
  input  logic          run_ok_i,
  input  logic [TO_W:0] load_val_i,
  output logic [TO_W:0] count_o,
  output logic [TO_W:0] next_count_o,
  output logic          running_o,
  output logic          step_o,
  output logic          expire_o
);
  logic [TO_W:0] cnt_q;
  logic          run_q;

  assign step_o       = tick_i && run_q && !hold_i;
  assign next_count_o = cnt_q - 1'b1;
  assign expire_o     = step_o && (cnt_q == {{TO_W{1'b0}}, 1'b1});
  assign count_o      = cnt_q;
  assign running_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= run_ok_i ? load_val_i : '0;
      run_q <= run_ok_i;
    end else if (reload_i) begin
      if (run_ok_i) cnt_q <= load_val_i;
    end else if (step_o) begin
      cnt_q <= next_count_o;
      if (expire_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_early_warn.sv
module wdog_early_warn
  import wdog_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            arm_i,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic [TO_W:0]   next_count_i,
  input  logic [TO_W-1:0] thr_i,
  output logic            armed_o,
  output logic            stat_o
);
  logic armed_q, stat_q, fire;

  assign fire    = armed_q && step_i && (next_count_i == {1'b0, thr_i});
  assign armed_o = armed_q;
  assign stat_o  = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      if (start_i)   armed_q <= arm_i;
      else if (fire) armed_q <= 1'b0;
      if (clear_i)   stat_q <= 1'b0;
      else if (fire) stat_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter bit               PT_EN   = 1'b1,
  parameter logic [REG_W-1:0] KEY_A   = 16'h5555,
  parameter logic [REG_W-1:0] KEY_B   = 16'hAAAA,
  parameter logic [TO_W-1:0]  THR_RST = 8'd4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             expire_i,
  input  logic             pt_stat_i,
  input  logic             cd_running_i,
  input  logic [TO_W:0]    cd_count_i,
  output logic             ctl_start_o,
  output logic             svc_reload_o,
  output logic             pt_start_o,
  output logic             pt_clear_o,
  output logic             pt_arm_o,
  output logic             run_ok_o,
  output logic [TO_W:0]    load_val_o,
  output logic [TO_W-1:0]  thr_o,
  output logic             imm_req_o,
  output logic             ctl_en_o,
  output logic [TO_W-1:0]  timeout_o
);
  logic [REG_W-1:0] ctl_q, svc_q, ctl_v;
  logic [1:0]       why_q;
  logic             ie_q, pde_q, ctl_seen_q, icr_seen_q;
  logic [TO_W-1:0]  thr_q, thr_v, new_to, cur_to;
  logic             ie_v, new_run, cur_run;
  logic [TO_W:0]    load_new, load_cur;
  logic             ctl_hit, svc_hit, icr_hit, misc_hit;

  assign ctl_hit  = we_i && (addr_i == OFF_CTL);
  assign svc_hit  = we_i && (addr_i == OFF_SVC);
  assign icr_hit  = we_i && (addr_i == OFF_ICR) && PT_EN;
  assign misc_hit = we_i && (addr_i == OFF_MISC);

  // lock handling on a control write
  always_comb begin
    ctl_v = wdata_i;
    if (ctl_seen_q) ctl_v[CB_LOCK_HI:CB_LOCK_LO] = ctl_q[CB_LOCK_HI:CB_LOCK_LO];
    if (ctl_q[CB_EN]) ctl_v[CB_EN] = 1'b1;
  end

  assign new_to   = ctl_v[CB_TO_LSB +: TO_W];
  assign cur_to   = ctl_q[CB_TO_LSB +: TO_W];
  assign new_run  = ctl_v[CB_EN] && (new_to != '0);
  assign cur_run  = ctl_q[CB_EN] && (cur_to != '0);
  assign load_new = {1'b0, new_to} + {{TO_W{1'b0}}, 1'b1};
  assign load_cur = {1'b0, cur_to} + {{TO_W{1'b0}}, 1'b1};

  assign ie_v  = icr_seen_q ? ie_q  : wdata_i[IB_IE];
  assign thr_v = icr_seen_q ? thr_q : wdata_i[TO_W-1:0];

  assign ctl_start_o  = ctl_hit;
  assign svc_reload_o = svc_hit && (svc_q == KEY_A) && (wdata_i == KEY_B) && cur_run;
  assign run_ok_o     = ctl_hit ? new_run : cur_run;
  assign load_val_o   = ctl_hit ? load_new : load_cur;
  assign pt_start_o   = ctl_hit || icr_hit;
  assign pt_clear_o   = icr_hit && wdata_i[IB_STAT];
  assign pt_arm_o     = ctl_hit ? (ie_q && new_run && (load_new > {1'b0, thr_q}))
                                : (ie_v && cd_running_i && (cd_count_i > {1'b0, thr_v}));
  assign imm_req_o    = ctl_hit && ((!ctl_v[CB_SWRST_N] && !ctl_v[CB_ASSERT]) ||
                                    (ctl_v[CB_EN] && (new_to == '0)));
  assign thr_o        = thr_q;
  assign ctl_en_o     = ctl_q[CB_EN];
  assign timeout_o    = cur_to;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= CTL_RST;
      svc_q      <= '0;
      why_q      <= WHY_NONE;
      ie_q       <= 1'b0;
      thr_q      <= THR_RST;
      pde_q      <= 1'b1;
      ctl_seen_q <= 1'b0;
      icr_seen_q <= 1'b0;
    end else begin
      if (ctl_hit) begin
        ctl_q             <= ctl_v;
        ctl_q[CB_SWRST_N] <= 1'b1;
        ctl_seen_q        <= 1'b1;
      end
      if (ctl_hit && !ctl_v[CB_SWRST_N]) why_q <= WHY_SOFT;
      else if (expire_i)                 why_q <= WHY_TOUT;
      if (svc_hit) svc_q <= wdata_i;
      if (icr_hit) begin
        ie_q       <= ie_v;
        thr_q      <= thr_v;
        icr_seen_q <= 1'b1;
      end
      if (misc_hit) pde_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTL:  rdata_o = ctl_q;
      OFF_SVC:  rdata_o = svc_q;
      OFF_WHY:  rdata_o[1:0] = why_q;
      OFF_ICR: begin
        rdata_o[IB_IE]      = ie_q;
        rdata_o[IB_STAT]    = pt_stat_i;
        rdata_o[TO_W-1:0]   = thr_q;
      end
      OFF_MISC: rdata_o[0] = pde_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
  import wdog_pkg::*;
#(
  parameter bit               PT_EN   = 1'b1,
  parameter logic [REG_W-1:0] KEY_A   = 16'h5555,
  parameter logic [REG_W-1:0] KEY_B   = 16'hAAAA,
  parameter logic [TO_W-1:0]  THR_RST = 8'd4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             csr_we_i,
  input  logic [AW-1:0]    csr_addr_i,
  input  logic [REG_W-1:0] csr_wdata_i,
  output logic [REG_W-1:0] csr_rdata_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  logic            ctl_start, svc_reload, pt_start, pt_clear, pt_arm, run_ok;
  logic [TO_W:0]   load_val, cd_count, cd_next;
  logic [TO_W-1:0] thr, timeout;
  logic            imm_req, ctl_en, cd_running, cd_step, cd_expire;
  logic            pt_stat, pt_armed, rst_req_q;

  wdog_regs #(.PT_EN(PT_EN), .KEY_A(KEY_A), .KEY_B(KEY_B), .THR_RST(THR_RST)) u_regs (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i), .rdata_o(csr_rdata_o),
    .expire_i(cd_expire), .pt_stat_i(pt_stat), .cd_running_i(cd_running), .cd_count_i(cd_count),
    .ctl_start_o(ctl_start), .svc_reload_o(svc_reload), .pt_start_o(pt_start),
    .pt_clear_o(pt_clear), .pt_arm_o(pt_arm), .run_ok_o(run_ok), .load_val_o(load_val),
    .thr_o(thr), .imm_req_o(imm_req), .ctl_en_o(ctl_en), .timeout_o(timeout)
  );

  wdog_countdown u_cd (
    .clk_i, .rst_ni, .tick_i, .hold_i(csr_we_i),
    .start_i(ctl_start), .reload_i(svc_reload), .run_ok_i(run_ok), .load_val_i(load_val),
    .count_o(cd_count), .next_count_o(cd_next), .running_o(cd_running),
    .step_o(cd_step), .expire_o(cd_expire)
  );

  generate
    if (PT_EN) begin : g_warn
      wdog_early_warn u_warn (
        .clk_i, .rst_ni, .start_i(pt_start), .arm_i(pt_arm), .clear_i(pt_clear),
        .step_i(cd_step), .next_count_i(cd_next), .thr_i(thr),
        .armed_o(pt_armed), .stat_o(pt_stat)
      );
    end else begin : g_no_warn
      assign pt_armed = 1'b0;
      assign pt_stat  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= imm_req || (cd_expire && ctl_en);
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = pt_stat;
endmodule

// File: rtl/wdog_pretimeout_chk.sv
module wdog_pretimeout_chk
  import wdog_pkg::*;
#(
  parameter bit PT_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_we_i,
  input logic [AW-1:0]    csr_addr_i,
  input logic [REG_W-1:0] csr_wdata_i,
  input logic [REG_W-1:0] csr_rdata_o,
  input logic             rst_req_o,
  input logic             irq_o,
  input logic             cd_expire,
  input logic             cd_running,
  input logic             ctl_en,
  input logic [TO_W-1:0]  timeout,
  input logic             pt_armed
);
  assert_expire_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_expire |=> rst_req_o);

  assert_expire_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_expire && !csr_we_i) |=> (csr_addr_i != OFF_WHY) || (csr_rdata_o == 16'h0002));

  assert_run_needs_timeout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_running |-> (ctl_en && (timeout != '0)));

  assert_enable_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en |=> ctl_en);

  assert_stat_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PT_EN && csr_we_i && (csr_addr_i == OFF_ICR) && csr_wdata_i[IB_STAT]) |=> !irq_o);

  assert_arm_only_by_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pt_armed) |-> $past(csr_we_i && ((csr_addr_i == OFF_CTL) || (csr_addr_i == OFF_ICR))));

  assert_no_irq_without_pt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !PT_EN |-> !irq_o);
endmodule

bind wdog_pretimeout wdog_pretimeout_chk #(.PT_EN(PT_EN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
  .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .rst_req_o(rst_req_o),
  .irq_o(irq_o), .cd_expire(cd_expire), .cd_running(cd_running), .ctl_en(ctl_en),
  .timeout(timeout), .pt_armed(pt_armed)
);

// File: tb/wdog_pretimeout_tb.sv
`timescale 1ns/1ps
module wdog_pretimeout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata, rdata_np;
  logic        rst_req, irq, rst_req_np, irq_np;

  int n_chk = 0, n_fail = 0, pulses = 0;

  always #2 clk = ~clk;

  wdog_pretimeout #(.PT_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq));

  wdog_pretimeout #(.PT_EN(1'b0)) u_dut_nopt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata_np), .rst_req_o(rst_req_np), .irq_o(irq_np));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_ctl, m_svc;
  int          m_cnt, m_thr;
  bit          m_run, m_armed, m_pst, m_ie, m_cseen, m_iseen, m_rreq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 16'h0030; m_svc = 0; m_cnt = 0; m_thr = 4; m_run = 0; m_armed = 0;
      m_pst = 0; m_ie = 0; m_cseen = 0; m_iseen = 0; m_rreq = 0;
    end else begin
      m_rreq = 0;
      if (we) begin
        if (addr == 4'h0) begin
          logic [15:0] v;
          int t;
          v = wdata;
          if (m_cseen) v[1:0] = m_ctl[1:0];
          if (m_ctl[2]) v[2] = 1'b1;
          m_cseen = 1;
          t = int'(v[15:8]);
          if ((!v[4] && !v[5]) || (v[2] && t == 0)) m_rreq = 1;
          v[4] = 1'b1;
          m_ctl = v;
          m_run = v[2] && t != 0;
          m_cnt = m_run ? t + 1 : 0;
          m_armed = m_ie && m_run && m_cnt > m_thr;
        end else if (addr == 4'h2) begin
          if (m_svc == 16'h5555 && wdata == 16'hAAAA && m_ctl[2] && m_ctl[15:8] != 0)
            m_cnt = int'(m_ctl[15:8]) + 1;
          m_svc = wdata;
        end else if (addr == 4'h6) begin
          if (!m_iseen) begin m_ie = wdata[15]; m_thr = int'(wdata[7:0]); end
          m_iseen = 1;
          if (wdata[14]) m_pst = 0;
          m_armed = m_ie && m_run && m_cnt > m_thr;
        end
      end else if (tick && m_run) begin
        m_cnt--;
        if (m_armed && m_cnt == m_thr) begin m_pst = 1; m_armed = 0; end
        if (m_cnt == 0) begin m_run = 0; m_rreq = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) pulses++;
      chk(rst_req == m_rreq, "R4 rst_req vs model", rst_req, m_rreq);
      chk(irq == m_pst, "R8 irq vs model", irq, m_pst);
      chk(irq_np == 1'b0, "R11 irq without pretimeout", irq_np, 0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr_tick(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; tick = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; tick = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic chk_pulses(input int exp, input string tag);
    @(negedge clk); #1;
    chk(pulses == exp, tag, pulses, exp);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(4'h0, 16'h0030, "R1 control reset");
    rd(4'h2, 16'h0000, "R1 service reset");
    rd(4'h4, 16'h0000, "R1 cause reset");
    rd(4'h6, 16'h0004, "R1 intctl reset");
    rd(4'h8, 16'h0001, "R1 misc reset");
    rd(4'hA, 16'h0000, "R1 unmapped");
    chk(rst_req == 0 && irq == 0, "R1 outputs low", {rst_req, irq}, 0);
    // R12 misc
    wr(4'h8, 16'hFFFE); rd(4'h8, 16'h0000, "R12 misc keeps bit0 only");
    wr(4'h8, 16'h0003); rd(4'h8, 16'h0001, "R12 misc set");
    // R8 early warning: ie=1, H=2, T=5
    wr(4'h6, 16'h8002); rd(4'h6, 16'h8002, "R8 intctl write");
    wr(4'h0, 16'h0534); rd(4'h0, 16'h0534, "R2 control readback");
    tk(3); #1 chk(irq == 0, "R8 irq before threshold", irq, 0);
    tk(1); #1 chk(irq == 1, "R8 irq at threshold", irq, 1);
    rd(4'h6, 16'hC002, "R8 status bit set");
    // R9 clear while count equals H (no re-arm), fields locked
    wr(4'h6, 16'h4000); rd(4'h6, 16'h8002, "R9 W1C and field lock");
    chk(irq == 0, "R9 irq cleared", irq, 0);
    // R10 service reload keeps warning quiet
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    rd(4'h2, 16'hAAAA, "R3 service readback");
    tk(4); #1 chk(irq == 0, "R10 no re-arm after service", irq, 0);
    chk_pulses(0, "R3 reload delayed expiry");
    tk(2); chk_pulses(1, "R4 expiry pulse");
    rd(4'h4, 16'h0002, "R4 timeout cause");
    // R3 broken pair
    wr(4'h0, 16'h0334);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    tk(4); chk_pulses(2, "R3 broken pair no reload");
    wr(4'h0, 16'h0334); tk(2);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tk(3); chk_pulses(2, "R3 good pair reloads");
    tk(1); chk_pulses(3, "R2 expiry after T+1 ticks");
    // R7 / R6
    wr(4'h0, 16'h0030); chk_pulses(4, "R6 enable with zero timeout");
    rd(4'h0, 16'h0034, "R7 enable sticky");
    wr(4'h0, 16'h0337); rd(4'h0, 16'h0334, "R7 low bits write-once");
    // R5 software reset bit
    wr(4'h0, 16'h0324); rd(4'h4, 16'h0001, "R5 soft cause");
    rd(4'h0, 16'h0334, "R5 bit reads 1");
    chk_pulses(4, "R5 no request with assert bit set");
    wr(4'h0, 16'h0304); chk_pulses(5, "R6 both bits clear");
    rd(4'h0, 16'h0314, "R6 control readback");
    // R13 tick during write dropped
    wr(4'h0, 16'h0234);
    wr_tick(4'h8, 16'h0001);
    tk(2); chk_pulses(5, "R13 tick dropped during write");
    tk(1); chk_pulses(6, "R13 expiry one tick later");
    // R11 no pretimeout variant
    @(negedge clk); addr = 4'h6; #1;
    chk(rdata_np == 16'h0004, "R11 intctl ignored", rdata_np, 16'h0004);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule